// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a host bus and a NOR-style flash array and turns bus write cycles that carry command bytes into array operations. Single-byte commands switch what a read returns (array data, the status byte or identification words), clear the error flags, or suspend and resume a running operation. Two-byte commands pair a setup byte with a confirm byte and start an erase, a chip erase, a word program or a lock-configuration change. Each bus write arrives as a one-cycle strobe with an address and a command byte.

The array itself is not modelled. A countdown timer stands in for the program and erase time, with one cycle count per operation class. A neighbouring protection block looks at the pending operation kind, the pending address and the lock bits this block exports, and answers with a single permit input. A low-programming-supply flag comes in as a plain input. Both inputs are sampled in the cycle of the confirm write. A block erase can be paused so that the host can read or program words, and that nested program can itself be paused for reads. A stand-alone program can be paused only for reads. A power-down input aborts whatever is running.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `rd_src` is 0 (array), the ready/busy pin is driven high (`rb_oe`=1, `rb_val`=1), no lock bit is set, and the status byte reads 80h.
- R2: Byte 70h selects status reads (`rd_src`=1), 90h selects identifier reads (`rd_src`=2) and FFh selects array reads (`rd_src`=0). Each takes effect one cycle after the write is taken.
- R3: In identifier mode the upper byte of `rd_data` is 00h. Address 0 reads B0h and address 1 reads E9h. Address 3 returns the permanent lock bit in bit 0. Any address whose offset within its block is 2 returns that block's lock bit in bit 0. Every other address reads 0.
- R4: A confirmed operation drives ready/busy low (`rb_oe`=1, `rb_val`=0) and clears status bit 7 for exactly its parameter cycle count: erase 20h+D0h, chip erase 30h+D0h, program 40h or 10h followed by any data byte, lock 60h followed by 01h, F1h or D0h.
- R5: After a setup or confirm byte, reads return status until FFh is written, including after the operation has finished. While an operation is running, every byte except B0h is ignored.
- R6: A setup byte followed by a byte that does not confirm it starts nothing and sets status bits 5 and 4 together.
- R7: If the permit input is low at the confirm write, no busy period follows. Status bit 1 is set, together with bit 5 for erase, chip erase or clear-lock, or bit 4 for program, set-lock or permanent lock.
- R8: If the low-supply input is high at the confirm write, no busy period follows. Status bit 3 is set, together with the matching error bit chosen as in R7.
- R9: Error bits 5, 4, 3 and 1 stay set until 50h is written, which clears them. Bit 0 always reads 0.
- R10: B0h during a block erase pauses it. Status reads C0h (bit 7 ready, bit 6 paused erase) and the ready/busy pin floats (`rb_oe`=0). D0h resumes the erase with only the cycles it had left.
- R11: While an erase is paused, a program sequence runs to completion and then returns the block to the paused-erase state. B0h during that program pauses it as well, and status then reads C4h (bit 2 set).
- R12: B0h during a stand-alone program sets status bit 2 and floats the pin. While that program is paused, setup bytes are ignored.
- R13: 60h+01h sets the lock bit of the addressed block, 60h+F1h sets the permanent lock bit, and 60h+D0h clears every block lock bit but leaves the permanent bit set.
- R14: Holding `pdown_n` low aborts any operation, selects array reads, drives ready/busy high, ignores bus writes, and leaves status at 80h afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pdown_n | input | 1 | Power-down/abort, active low |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Command or data byte |
| op_ok | input | 1 | Permit from the protection block, sampled at confirm |
| vpp_low | input | 1 | Low programming supply flag, sampled at confirm |
| rd_addr | input | ADDR_W | Read address for identifier words |
| rd_src | output | 2 | Read source: 0 array, 1 status, 2 identifier |
| rd_data | output | 16 | Status or identifier word (0 in array mode) |
| rb_oe | output | 1 | Ready/busy pin drive enable (0 = floating) |
| rb_val | output | 1 | Ready/busy level when driven (0 = busy) |
| pend_kind | output | 3 | Pending setup: 0 none, 1 erase, 2 chip, 3 program, 4 lock |
| pend_addr | output | ADDR_W | Address captured with the setup byte |
| lock_map | output | NBLK | Block lock bits |
| perm_lock | output | 1 | Permanent lock bit |

## Verification
State changes at the clock edge that samples a write strobe. `rd_src`, `rd_data` and the ready/busy pair are registered from that state, so every result shows up one edge after the write is taken. The bench therefore waits one edge after each write's edge and samples on the falling edge. A busy period started at edge k shows the pin low after edges k+1 through k+N, where N is the cycle count, and high after edge k+N+1. The bench checks both sides of that boundary. After a pause it does the same with the remaining count: the full count minus the edges that ran before the B0h edge, counting the B0h edge itself.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CB_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CB_READ_STAT  = 8'h70;
  localparam logic [7:0] CB_CLR_STAT   = 8'h50;
  localparam logic [7:0] CB_READ_ID    = 8'h90;
  localparam logic [7:0] CB_SUSPEND    = 8'hB0;
  localparam logic [7:0] CB_CONFIRM    = 8'hD0;
  localparam logic [7:0] CB_ERASE      = 8'h20;
  localparam logic [7:0] CB_CHIP       = 8'h30;
  localparam logic [7:0] CB_PROG_A     = 8'h40;
  localparam logic [7:0] CB_PROG_B     = 8'h10;
  localparam logic [7:0] CB_LOCKCFG    = 8'h60;
  localparam logic [7:0] CB_LK_SET     = 8'h01;
  localparam logic [7:0] CB_LK_PERM    = 8'hF1;

  localparam logic [7:0] ID_MAKER  = 8'hB0;
  localparam logic [7:0] ID_DEVICE = 8'hE9;

  typedef enum logic [3:0] {
    C_NONE, C_RDARR, C_RDSTAT, C_CLR, C_RDID, C_SUSP, C_RESUME,
    C_ERS, C_CHIP, C_WR, C_LKCFG
  } cmd_e;

  typedef enum logic [1:0] {RM_ARRAY = 2'd0, RM_STATUS = 2'd1, RM_IDENT = 2'd2} rmode_e;

  typedef enum logic [1:0] {PS_IDLE, PS_BUSY, PS_SUSP} pstate_e;

  typedef enum logic [2:0] {
    PD_NONE = 3'd0, PD_ERASE = 3'd1, PD_CHIP = 3'd2, PD_WRITE = 3'd3, PD_LOCK = 3'd4
  } pend_e;

  typedef enum logic [2:0] {K_ERASE, K_CHIP, K_WRITE, K_SETLK, K_CLRLK, K_PERM} kind_e;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [7:0] code,
  output cmd_e       cmd
);
  always_comb begin
    case (code)
      CB_READ_ARRAY:       cmd = C_RDARR;
      CB_READ_STAT:        cmd = C_RDSTAT;
      CB_CLR_STAT:         cmd = C_CLR;
      CB_READ_ID:          cmd = C_RDID;
      CB_SUSPEND:          cmd = C_SUSP;
      CB_CONFIRM:          cmd = C_RESUME;
      CB_ERASE:            cmd = C_ERS;
      CB_CHIP:             cmd = C_CHIP;
      CB_PROG_A, CB_PROG_B: cmd = C_WR;
      CB_LOCKCFG:          cmd = C_LKCFG;
      default:             cmd = C_NONE;
    endcase
  end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CW = 8
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)                cnt <= '0;
    else if (load)                 cnt <= load_val;
    else if (run && cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == CW'(1));

  // R4: an operation finishes in one cycle, never twice in a row
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    (done && !load && !clr) |=> !done);
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int NBLK   = 8,
  parameter int BLK_AW = 6,
  parameter int BLK_W  = 3,
  parameter int ADDR_W = 9
)(
  input  logic              clk,
  input  logic              rst,
  input  rmode_e            mode,
  input  logic [7:0]        sr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NBLK-1:0]   lock_map,
  input  logic              perm_lock,
  output logic [1:0]        rd_src,
  output logic [15:0]       rd_data
);
  logic [BLK_AW-1:0] off;
  logic [BLK_W-1:0]  blk;
  logic [7:0]        id_byte;

  assign off = rd_addr[BLK_AW-1:0];
  assign blk = rd_addr[ADDR_W-1:BLK_AW];

  always_comb begin
    if (rd_addr == ADDR_W'(0))      id_byte = ID_MAKER;
    else if (rd_addr == ADDR_W'(1)) id_byte = ID_DEVICE;
    else if (rd_addr == ADDR_W'(3)) id_byte = {7'd0, perm_lock};
    else if (off == BLK_AW'(2))     id_byte = {7'd0, lock_map[blk]};
    else                            id_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_src  <= 2'd0;
      rd_data <= '0;
    end else begin
      case (mode)
        RM_STATUS: begin rd_src <= 2'd1; rd_data <= {8'h00, sr};      end
        RM_IDENT:  begin rd_src <= 2'd2; rd_data <= {8'h00, id_byte}; end
        default:   begin rd_src <= 2'd0; rd_data <= '0;               end
      endcase
    end
  end

  // R9: the reserved status bit reaches the read port as 0
  a_r9_sr0_low: assert property (@(posedge clk) disable iff (rst)
    (mode == RM_STATUS) |=> (rd_data[0] == 1'b0));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int NBLK      = 8,
  parameter int BLK_AW    = 6,
  parameter int ERASE_CYC = 24,
  parameter int CHIP_CYC  = 40,
  parameter int WRITE_CYC = 6,
  parameter int LOCK_CYC  = 4,
  localparam int BLK_W    = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int ADDR_W   = BLK_W + BLK_AW
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              pdown_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              op_ok,
  input  logic              vpp_low,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_src,
  output logic [15:0]       rd_data,
  output logic              rb_oe,
  output logic              rb_val,
  output logic [2:0]        pend_kind,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [NBLK-1:0]   lock_map,
  output logic              perm_lock
);
  localparam int MAX_A = (ERASE_CYC > CHIP_CYC) ? ERASE_CYC : CHIP_CYC;
  localparam int MAX_B = (WRITE_CYC > LOCK_CYC) ? WRITE_CYC : LOCK_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXC + 1);

  pstate_e p_st, n_st;
  kind_e   p_kind;
  pend_e   pend;
  rmode_e  mode;
  logic [ADDR_W-1:0] pend_addr_q;
  logic s_esus, s_eerr, s_werr, s_vlow, s_wsus, s_prot;
  logic [NBLK-1:0] lock_q;
  logic perm_q;

  cmd_e cmd;
  flash_cmd_decode u_dec (.code(wr_data), .cmd(cmd));

  logic          acc, any_busy, nested, start;
  logic          conf_good, conf_ecls;
  kind_e         conf_kind;
  logic [CW-1:0] conf_cyc;
  logic [1:0]    tm_load, tm_run, tm_done;
  logic [CW-1:0] tm_val [2];
  logic [7:0]    sr;

  assign acc      = wr_stb && pdown_n;
  assign any_busy = (p_st == PS_BUSY) || (n_st == PS_BUSY);
  assign nested   = (p_st == PS_SUSP);

  always_comb begin
    conf_good = 1'b0;
    conf_kind = K_WRITE;
    conf_cyc  = CW'(WRITE_CYC);
    case (pend)
      PD_ERASE: begin conf_good = (wr_data == CB_CONFIRM); conf_kind = K_ERASE; conf_cyc = CW'(ERASE_CYC); end
      PD_CHIP:  begin conf_good = (wr_data == CB_CONFIRM); conf_kind = K_CHIP;  conf_cyc = CW'(CHIP_CYC);  end
      PD_WRITE: begin conf_good = 1'b1; end
      PD_LOCK: begin
        conf_cyc = CW'(LOCK_CYC);
        if (wr_data == CB_LK_SET)       begin conf_good = 1'b1; conf_kind = K_SETLK; end
        else if (wr_data == CB_LK_PERM) begin conf_good = 1'b1; conf_kind = K_PERM;  end
        else if (wr_data == CB_CONFIRM) begin conf_good = 1'b1; conf_kind = K_CLRLK; end
      end
      default: ;
    endcase
  end

  assign conf_ecls = (conf_kind == K_ERASE) || (conf_kind == K_CHIP) || (conf_kind == K_CLRLK);
  assign start     = acc && (pend != PD_NONE) && conf_good && op_ok && !vpp_low;

  // timer 0 runs the primary operation, timer 1 a program nested in a paused erase
  assign tm_load[0] = start && !nested;
  assign tm_load[1] = start && nested;
  assign tm_val[0]  = conf_cyc;
  assign tm_val[1]  = CW'(WRITE_CYC);
  assign tm_run[0]  = (p_st == PS_BUSY);
  assign tm_run[1]  = (n_st == PS_BUSY);

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    flash_op_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst(rst), .clr(!pdown_n), .load(tm_load[g]),
      .load_val(tm_val[g]), .run(tm_run[g]), .done(tm_done[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !pdown_n) begin
      p_st <= PS_IDLE; n_st <= PS_IDLE; p_kind <= K_WRITE;
      pend <= PD_NONE; mode <= RM_ARRAY;
      s_esus <= 1'b0; s_eerr <= 1'b0; s_werr <= 1'b0;
      s_vlow <= 1'b0; s_wsus <= 1'b0; s_prot <= 1'b0;
      if (rst) begin
        pend_addr_q <= '0; lock_q <= '0; perm_q <= 1'b0;
      end
    end else begin
      if (p_st == PS_BUSY && tm_done[0]) begin
        p_st <= PS_IDLE;
        case (p_kind)
          K_SETLK: lock_q[pend_addr_q[ADDR_W-1:BLK_AW]] <= 1'b1;
          K_CLRLK: lock_q <= '0;
          K_PERM:  perm_q <= 1'b1;
          default: ;
        endcase
      end
      if (n_st == PS_BUSY && tm_done[1]) n_st <= PS_IDLE;

      if (acc) begin
        if (pend != PD_NONE) begin
          pend <= PD_NONE;
          mode <= RM_STATUS;
          if (!conf_good) begin
            s_eerr <= 1'b1; s_werr <= 1'b1;
          end else if (vpp_low || !op_ok) begin
            if (vpp_low) s_vlow <= 1'b1;
            else         s_prot <= 1'b1;
            if (conf_ecls) s_eerr <= 1'b1;
            else           s_werr <= 1'b1;
          end else if (nested) begin
            n_st <= PS_BUSY;
          end else begin
            p_st <= PS_BUSY; p_kind <= conf_kind;
          end
        end else if (any_busy) begin
          if (cmd == C_SUSP) begin
            if (n_st == PS_BUSY) begin
              if (!tm_done[1]) begin n_st <= PS_SUSP; s_wsus <= 1'b1; end
            end else if (!tm_done[0] && p_kind == K_ERASE) begin
              p_st <= PS_SUSP; s_esus <= 1'b1;
            end else if (!tm_done[0] && p_kind == K_WRITE) begin
              p_st <= PS_SUSP; s_wsus <= 1'b1;
            end
          end
        end else begin
          case (cmd)
            C_RDARR:  mode <= RM_ARRAY;
            C_RDSTAT: mode <= RM_STATUS;
            C_RDID:   mode <= RM_IDENT;
            C_CLR: begin
              s_eerr <= 1'b0; s_werr <= 1'b0; s_vlow <= 1'b0; s_prot <= 1'b0;
            end
            C_RESUME: begin
              if (n_st == PS_SUSP) begin
                n_st <= PS_BUSY; s_wsus <= 1'b0; mode <= RM_STATUS;
              end else if (p_st == PS_SUSP) begin
                p_st <= PS_BUSY; s_esus <= 1'b0; s_wsus <= 1'b0; mode <= RM_STATUS;
              end
            end
            C_ERS, C_CHIP, C_LKCFG: begin
              if (p_st == PS_IDLE) begin
                pend <= (cmd == C_ERS) ? PD_ERASE : (cmd == C_CHIP) ? PD_CHIP : PD_LOCK;
                pend_addr_q <= wr_addr;
                mode <= RM_STATUS;
              end
            end
            C_WR: begin
              if (p_st == PS_IDLE ||
                  (p_st == PS_SUSP && p_kind == K_ERASE && n_st == PS_IDLE)) begin
                pend <= PD_WRITE; pend_addr_q <= wr_addr; mode <= RM_STATUS;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sr = {!any_busy, s_esus, s_eerr, s_werr, s_vlow, s_wsus, s_prot, 1'b0};

  always_ff @(posedge clk) begin
    if (rst || !pdown_n)      begin rb_oe <= 1'b1; rb_val <= 1'b1; end
    else if (any_busy)        begin rb_oe <= 1'b1; rb_val <= 1'b0; end
    else if (p_st == PS_SUSP) begin rb_oe <= 1'b0; rb_val <= 1'b1; end
    else                      begin rb_oe <= 1'b1; rb_val <= 1'b1; end
  end

  flash_read_mux #(.NBLK(NBLK), .BLK_AW(BLK_AW), .BLK_W(BLK_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .mode(mode), .sr(sr), .rd_addr(rd_addr),
    .lock_map(lock_q), .perm_lock(perm_q), .rd_src(rd_src), .rd_data(rd_data)
  );

  assign pend_kind = pend;
  assign pend_addr = pend_addr_q;
  assign lock_map  = lock_q;
  assign perm_lock = perm_q;

  // R4: a running operation pulls the ready/busy pin low one cycle later
  a_r4_busy_low: assert property (@(posedge clk) disable iff (rst)
    (any_busy && pdown_n) |=> (rb_oe && !rb_val));

  // R10: a paused operation with nothing nested floats the pin
  a_r10_susp_float: assert property (@(posedge clk) disable iff (rst)
    (p_st == PS_SUSP && n_st == PS_IDLE && pdown_n) |=> !rb_oe);

  // R6: a rejected confirm leaves both error flags raised
  a_r6_bad_confirm: assert property (@(posedge clk) disable iff (rst)
    (acc && pend != PD_NONE && !conf_good) |=> (s_eerr && s_werr));

  // R11: a nested program exists only under a paused block erase
  a_r11_nest_under_erase: assert property (@(posedge clk) disable iff (rst)
    (n_st != PS_IDLE) |-> (p_st == PS_SUSP && p_kind == K_ERASE));

  // R14: power-down returns to idle array reads
  a_r14_pdown_idle: assert property (@(posedge clk) disable iff (rst)
    !pdown_n |=> (p_st == PS_IDLE && n_st == PS_IDLE && mode == RM_ARRAY));
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
  localparam int NBLK = 8, BLK_AW = 6, ADDR_W = 9;
  localparam int ECYC = 24, CCYC = 40, WCYC = 6, LCYC = 4;

  logic clk = 1'b0, rst = 1'b1, pdown_n = 1'b1, wr_stb = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic op_ok = 1'b1, vpp_low = 1'b0;
  logic [1:0] rd_src;
  logic [15:0] rd_data;
  logic rb_oe, rb_val, perm_lock;
  logic [2:0] pend_kind;
  logic [ADDR_W-1:0] pend_addr;
  logic [NBLK-1:0] lock_map;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.NBLK(NBLK), .BLK_AW(BLK_AW), .ERASE_CYC(ECYC), .CHIP_CYC(CCYC),
                   .WRITE_CYC(WCYC), .LOCK_CYC(LCYC)) dut (
    .clk(clk), .rst(rst), .pdown_n(pdown_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_ok(op_ok), .vpp_low(vpp_low), .rd_addr(rd_addr),
    .rd_src(rd_src), .rd_data(rd_data), .rb_oe(rb_oe), .rb_val(rb_val),
    .pend_kind(pend_kind), .pend_addr(pend_addr), .lock_map(lock_map), .perm_lock(perm_lock));

  // {byte, expected rd_src, expected rd_data}, all at address 0
  localparam logic [25:0] VEC [13] = '{
    {8'h70, 2'd1, 16'h0080}, {8'h90, 2'd2, 16'h00B0}, {8'hFF, 2'd0, 16'h0000},
    {8'h20, 2'd1, 16'h0080}, {8'h55, 2'd1, 16'h00B0}, {8'hFF, 2'd0, 16'h0000},
    {8'h70, 2'd1, 16'h00B0}, {8'h50, 2'd1, 16'h0080}, {8'h60, 2'd1, 16'h0080},
    {8'h33, 2'd1, 16'h00B0}, {8'h50, 2'd1, 16'h0080}, {8'h90, 2'd2, 16'h00B0},
    {8'hFF, 2'd0, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, input logic [ADDR_W-1:0] a);
    wr_stb = 1'b1; wr_data = d; wr_addr = a;
    @(posedge clk);
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 src", rd_src, 0);
    chk("R1 pin", {rb_oe, rb_val}, 2'b11);
    chk("R1 locks", {lock_map, perm_lock}, 0);

    // R2 R5 R6 R9 table
    for (int i = 0; i < 13; i++) begin
      wr(VEC[i][25:18], '0);
      step(1);
      chk($sformatf("R2/R5/R6/R9 vec%0d src", i), rd_src, VEC[i][17:16]);
      chk($sformatf("R2/R5/R6/R9 vec%0d data", i), rd_data, VEC[i][15:0]);
    end

    // R3 identifier words
    wr(8'h90, '0);
    rd_addr = 9'd1; step(1); chk("R3 device", rd_data, 16'h00E9);
    rd_addr = 9'd3; step(1); chk("R3 perm", rd_data, 16'h0000);
    rd_addr = 9'd130; step(1); chk("R3 blk lock", rd_data, 16'h0000);
    rd_addr = 9'd5; step(1); chk("R3 other", rd_data, 16'h0000);
    rd_addr = '0;

    // R4 R5 erase busy window
    wr(8'h20, 9'd64); wr(8'hD0, 9'd64);
    step(1);
    chk("R4 busy pin", {rb_oe, rb_val}, 2'b10);
    chk("R4 sr7", rd_data[7], 0);
    step(ECYC - 1);
    chk("R4 last busy", {rb_oe, rb_val}, 2'b10);
    step(1);
    chk("R4 ready", {rb_oe, rb_val}, 2'b11);
    chk("R5 still status", {rd_src, rd_data}, {2'd1, 16'h0080});

    // R7 permit denied
    op_ok = 1'b0;
    wr(8'h30, '0); wr(8'hD0, '0);
    op_ok = 1'b1;
    step(1);
    chk("R7 no busy", {rb_oe, rb_val}, 2'b11);
    chk("R7 status", rd_data, 16'h00A2);
    wr(8'h50, '0); step(1);
    chk("R9 cleared", rd_data, 16'h0080);

    // R8 low supply
    vpp_low = 1'b1;
    wr(8'h40, 9'd10); wr(8'h5A, 9'd10);
    vpp_low = 1'b0;
    step(1);
    chk("R8 status", rd_data, 16'h0098);
    chk("R8 no busy", {rb_oe, rb_val}, 2'b11);
    wr(8'h50, '0);

    // R10 erase suspend
    wr(8'h20, 9'd64); wr(8'hD0, 9'd64);
    step(4);
    wr(8'hB0, '0);
    step(1);
    chk("R10 suspended", rd_data, 16'h00C0);
    chk("R10 float", rb_oe, 0);
    wr(8'hFF, '0); step(1);
    chk("R10 array read", rd_src, 0);

    // R11 nested program
    wr(8'h40, 9'd200); wr(8'h12, 9'd200);
    step(1);
    chk("R11 nested busy", {rb_oe, rb_val}, 2'b10);
    step(1);
    wr(8'hB0, '0); step(1);
    chk("R11 nested pause", rd_data, 16'h00C4);
    chk("R11 float", rb_oe, 0);
    wr(8'hD0, '0);
    step(WCYC);
    chk("R11 back to pause", rd_data, 16'h00C0);
    chk("R11 pin float", rb_oe, 0);

    // R10 resume with remaining count
    wr(8'hD0, '0);
    step(ECYC - 5);
    chk("R10 remaining busy", {rb_oe, rb_val}, 2'b10);
    step(1);
    chk("R10 done", {rb_oe, rb_val}, 2'b11);
    chk("R10 status", rd_data, 16'h0080);

    // R12 program suspend ignores setup
    wr(8'h40, 9'd20); wr(8'h77, 9'd20);
    step(1);
    wr(8'hB0, '0); step(1);
    chk("R12 paused", rd_data, 16'h0084);
    chk("R12 float", rb_oe, 0);
    wr(8'h20, '0); wr(8'h55, '0); step(1);
    chk("R12 setup ignored", rd_data, 16'h0084);
    wr(8'hD0, '0);
    step(WCYC + 1);
    chk("R12 finished", rd_data, 16'h0080);

    // R13 lock configuration
    wr(8'h60, 9'd128); wr(8'h01, 9'd128);
    step(LCYC + 1);
    chk("R13 set done", rd_data, 16'h0080);
    rd_addr = 9'd130; wr(8'h90, '0); step(1);
    chk("R13 block lock", rd_data, 16'h0001);
    chk("R13 lock map", lock_map, 8'b0000_0100);
    rd_addr = 9'd2; step(1);
    chk("R13 other block", rd_data, 16'h0000);
    wr(8'h60, '0); wr(8'hF1, '0);
    step(LCYC + 1);
    rd_addr = 9'd3; wr(8'h90, '0); step(1);
    chk("R13 perm set", rd_data, 16'h0001);
    wr(8'h60, '0); wr(8'hD0, '0);
    step(LCYC + 1);
    rd_addr = 9'd130; wr(8'h90, '0); step(1);
    chk("R13 cleared", rd_data, 16'h0000);
    rd_addr = 9'd3; step(1);
    chk("R13 perm kept", rd_data, 16'h0001);
    rd_addr = '0;

    // R14 power-down abort
    wr(8'h20, 9'd64); wr(8'hD0, 9'd64);
    step(2);
    pdown_n = 1'b0;
    step(2);
    chk("R14 pin high", {rb_oe, rb_val}, 2'b11);
    chk("R14 array", rd_src, 0);
    wr(8'h70, '0); step(1);
    chk("R14 write ignored", rd_src, 0);
    pdown_n = 1'b1;
    step(1);
    wr(8'h70, '0); step(1);
    chk("R14 status after", {rd_src, rd_data, rb_oe, rb_val}, {2'd1, 16'h0080, 2'b11});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule